// File: doc/BRIEF.md
# Pipelined Zero-Wait Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Its pipeline has no dead cycles, so reads, writes and deselects can be issued on consecutive clocks in any mix. The bus turns between reading and writing without an idle cycle. Every control and address input is registered on the rising clock edge. An active-low clock enable qualifies each edge, and when it is high the whole block freezes. Three chip selects qualify a new access. A load/advance pin either loads a fresh address or steps a two-bit burst counter through four beats. The step order is linear or interleaved.

Each word holds four byte lanes and one parity bit per lane. Lane `k` occupies data bits `[8k+7:8k]` and parity bit `32+k`. Writes are masked per lane. Read data leaves through an output register. Write data is taken two enabled edges after its address, which is the same slot where read data appears. This keeps the shared bus timing uniform. The bidirectional bus is split into an input port, an output port and a drive flag. The flag is gated combinationally by an active-low output enable.

Top module: `pipe_burst_sram`

## Requirements
- R1: While `rst_ni` is low and after its release, `drive_o` is 0 until a read has passed through the pipeline.
- R2: A read loaded at enabled edge n (`cen_ni`=0, `ld_ni`=0, all three selects active, `we_ni`=1) presents the word on `rdata_o` with `drive_o`=1 after the next enabled edge, when `oe_ni`=0.
- R3: A write loaded at enabled edge n takes `wdata_i` at the second enabled edge after n. A byte-write enable `bw_ni[k]`=0, captured with the address, updates data bits `[8k+7:8k]` and parity bit `32+k`. Lanes with `bw_ni[k]`=1 keep their old value.
- R4: Operations may be issued on every enabled edge with no idle cycles. A read issued right after a write to the same word returns the newly written lanes merged with the old ones.
- R5: An edge with `cen_ni`=1 changes no state. `rdata_o` and `drive_o` hold, no write is committed, and the burst position is kept.
- R6: `oe_ni`=1 forces `drive_o` to 0 at once, without a clock edge. Returning it to 0 restores drive.
- R7: A load with any select inactive (`ce_a_ni`=1, `ce_b_i`=0 or `ce_c_ni`=1) is a deselect, and `drive_o` is 0 after the next enabled edge. `drive_o` is also 0 during a write data slot and in the first cycle after leaving the deselected state.
- R8: With `burst_mode_i`=0, the advance beats i=1..3 after a load at base b use low address bits (b+i) mod 4. The fifth beat returns to b.
- R9: With `burst_mode_i`=1, the advance beats use low address bits b XOR i.
- R10: An advance (`ld_ni`=1) continues the loaded access type and ignores `we_ni` and the chip selects.
- R11: Advances that follow a deselect perform no access. They write nothing and do not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| ce_a_ni | input | 1 | Chip select A, active low |
| ce_b_i | input | 1 | Chip select B, active high |
| ce_c_ni | input | 1 | Chip select C, active low |
| ld_ni | input | 1 | 0 loads a new address, 1 advances the burst |
| we_ni | input | 1 | 0 write, 1 read (sampled on load) |
| bw_ni | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| burst_mode_i | input | 1 | 0 linear, 1 interleaved burst order |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | WORD_W | Write data, lanes plus parity |
| rdata_o | output | WORD_W | Registered read data |
| drive_o | output | 1 | Bus drive flag for rdata_o |

## Verification
The bench targets the read that immediately follows a write to the same word. A design without a bypass around the delayed write returns the stale word. Stalls are inserted between a write's capture and its data slot, with junk on `wdata_i`. A design that lets a frozen edge commit stores the junk or shifts the data slot. Bursts are run in both orders and past the wrap, and an advance is given a misleading `we_ni` and select level. A counter that wraps wrongly, or an advance that re-samples the access type, then writes or reads the wrong words. Advances issued after a deselect must leave memory untouched. Bus drive is checked in the write slot and in the first cycle out of deselect, where a wrong design drives stale data.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/psram_ctrl_stage.sv
module psram_ctrl_stage
  import psram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ld_ni,
  input  logic              sel_i,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              interleave_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  lane_en_o
);
  op_e                op_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [LANES-1:0]   lane_q;
  logic [BURST_W-1:0] beat_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      lane_q <= '0;
    end else if (en_i) begin
      lane_q <= ~bw_ni;
      if (!ld_ni) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        op_q   <= !sel_i ? OP_IDLE : (we_ni ? OP_READ : OP_WRITE);
      end else begin
        // advance keeps op type, ignores selects and we
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (interleave_i) beat_lo = base_q[BURST_W-1:0] ^ cnt_q;
    else              beat_lo = base_q[BURST_W-1:0] + cnt_q;
  end

  assign op_o      = op_q;
  assign addr_o    = {base_q[ADDR_W-1:BURST_W], beat_lo};
  assign lane_en_o = lane_q;
endmodule

// File: rtl/psram_lane_mask.sv
module psram_lane_mask #(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  localparam int WORD_W   = LANES * (LANE_BITS + 1)
) (
  input  logic [LANES-1:0]  lane_en_i,
  output logic [WORD_W-1:0] bit_en_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign bit_en_o[k*LANE_BITS +: LANE_BITS] = {LANE_BITS{lane_en_i[k]}};
    assign bit_en_o[LANES*LANE_BITS + k]      = lane_en_i[k];
  end
endmodule

// File: rtl/psram_core.sv
module psram_core #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 36,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] bit_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[waddr_i] <= (mem_q[waddr_i] & ~bit_en_i) | (wdata_i & bit_en_i);
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/psram_read_stage.sv
module psram_read_stage
  import psram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  op_e               rd_op_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] core_data_i,
  input  op_e               wr_op_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_bit_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              oe_ni,
  output logic [WORD_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              fwd_hit;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] data_q;
  logic              drive_q;

  // write committing this edge is not yet in the core
  assign fwd_hit = (wr_op_i == OP_WRITE) && (rd_op_i == OP_READ) && (wr_addr_i == rd_addr_i);
  assign rd_word = fwd_hit ? ((core_data_i & ~wr_bit_en_i) | (wdata_i & wr_bit_en_i)) : core_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      drive_q <= 1'b0;
    end else if (en_i) begin
      drive_q <= (rd_op_i == OP_READ);
      if (rd_op_i == OP_READ) data_q <= rd_word;
    end
  end

  assign rdata_o = data_q;
  assign drive_o = drive_q & ~oe_ni;
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import psram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  parameter int BURST_W   = 2,
  localparam int WORD_W   = LANES * (LANE_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ce_a_ni,
  input  logic              ce_b_i,
  input  logic              ce_c_ni,
  input  logic              ld_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              burst_mode_i,
  input  logic              oe_ni,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              en;
  logic              sel_all;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lane;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lane;
  logic [WORD_W-1:0] s2_bit_en;
  logic [WORD_W-1:0] core_rd;

  assign en      = ~cen_ni;
  assign sel_all = ~ce_a_ni & ce_b_i & ~ce_c_ni;

  psram_ctrl_stage #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .BURST_W(BURST_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .ld_ni       (ld_ni),
    .sel_i       (sel_all),
    .we_ni       (we_ni),
    .addr_i      (addr_i),
    .bw_ni       (bw_ni),
    .interleave_i(burst_mode_i),
    .op_o        (s1_op),
    .addr_o      (s1_addr),
    .lane_en_o   (s1_lane)
  );

  // stage 2: write data slot, aligned with read output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_lane <= '0;
    end else if (en) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_lane <= s1_lane;
    end
  end

  psram_lane_mask #(
    .LANES    (LANES),
    .LANE_BITS(LANE_BITS)
  ) u_mask (
    .lane_en_i(s2_lane),
    .bit_en_o (s2_bit_en)
  );

  psram_core #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) u_core (
    .clk_i   (clk_i),
    .wr_en_i (en && (s2_op == OP_WRITE)),
    .waddr_i (s2_addr),
    .bit_en_i(s2_bit_en),
    .wdata_i (wdata_i),
    .raddr_i (s1_addr),
    .rdata_o (core_rd)
  );

  psram_read_stage #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .rd_op_i    (s1_op),
    .rd_addr_i  (s1_addr),
    .core_data_i(core_rd),
    .wr_op_i    (s2_op),
    .wr_addr_i  (s2_addr),
    .wr_bit_en_i(s2_bit_en),
    .wdata_i    (wdata_i),
    .oe_ni      (oe_ni),
    .rdata_o    (rdata_o),
    .drive_o    (drive_o)
  );
endmodule

// File: rtl/pipe_burst_sram_chk.sv
module pipe_burst_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              ce_a_ni,
  input logic              ce_b_i,
  input logic              ce_c_ni,
  input logic              ld_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [WORD_W-1:0] rdata_o,
  input logic              drive_o
);
  logic sel_all;
  assign sel_all = ~ce_a_ni & ce_b_i & ~ce_c_ni;

  // R5
  cen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> $stable(rdata_o));

  // R2
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && sel_all && we_ni) ##1 !cen_ni |=> (oe_ni || drive_o));

  // R7
  desel_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && !sel_all) ##1 !cen_ni |=> !drive_o);

  // R7
  wr_slot_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && sel_all && !we_ni) ##1 !cen_ni |=> !drive_o);

  // R10
  burst_wr_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && sel_all && !we_ni) ##1 (!cen_ni && ld_ni) ##1 !cen_ni |=> !drive_o);
endmodule

bind pipe_burst_sram pipe_burst_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cen_ni (cen_ni),
  .ce_a_ni(ce_a_ni),
  .ce_b_i (ce_b_i),
  .ce_c_ni(ce_c_ni),
  .ld_ni  (ld_ni),
  .we_ni  (we_ni),
  .oe_ni  (oe_ni),
  .rdata_o(rdata_o),
  .drive_o(drive_o)
);

// File: tb/pipe_burst_sram_bench.sv
module pipe_burst_sram_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cen_ni = 1'b0;
  logic        ce_a_ni = 1'b1;
  logic        ce_b_i = 1'b0;
  logic        ce_c_ni = 1'b1;
  logic        ld_ni = 1'b0;
  logic        we_ni = 1'b1;
  logic [3:0]  bw_ni = 4'hF;
  logic [9:0]  addr_i = '0;
  logic        burst_mode_i = 1'b0;
  logic        oe_ni = 1'b0;
  logic [35:0] wdata_i = '0;
  logic [35:0] rdata_o;
  logic        drive_o;

  pipe_burst_sram u_pipe_burst_sram (
    .clk_i(clk_i), .rst_ni(rst_ni), .cen_ni(cen_ni), .ce_a_ni(ce_a_ni),
    .ce_b_i(ce_b_i), .ce_c_ni(ce_c_ni), .ld_ni(ld_ni), .we_ni(we_ni),
    .bw_ni(bw_ni), .addr_i(addr_i), .burst_mode_i(burst_mode_i), .oe_ni(oe_ni),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  int desel_rot = 0;
  bit done = 1'b0;

  logic [35:0] ref_mem [1024];

  // bench pipeline: kind 0 none, 1 read, 2 write
  int          p1_kind = 0, p2_kind = 0;
  logic [35:0] p1_exp = '0, p1_data = '0, p2_data = '0;
  string       p1_tag = "R1";
  logic [35:0] last_rd = '0;
  logic        last_dr = 1'b0;

  function automatic logic [35:0] apply_lanes(input logic [35:0] old, input logic [35:0] d,
                                              input logic [3:0] bwn);
    logic [35:0] r;
    r = old;
    for (int k = 0; k < 4; k++) begin
      if (!bwn[k]) begin
        r[k*8 +: 8] = d[k*8 +: 8];
        r[32+k]     = d[32+k];
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic cen, input logic ld, input logic sel, input logic we,
                     input logic [9:0] a, input logic [3:0] bwn, input int kind,
                     input logic [9:0] eff, input logic [35:0] d, input string tag);
    logic [35:0] nexp;
    nexp    = '0;
    cen_ni  = cen;
    ld_ni   = ld;
    we_ni   = we;
    addr_i  = a;
    bw_ni   = bwn;
    ce_a_ni = 1'b0; ce_b_i = 1'b1; ce_c_ni = 1'b0;
    if (!sel) begin
      case (desel_rot % 3)
        0:       ce_a_ni = 1'b1;
        1:       ce_b_i  = 1'b0;
        default: ce_c_ni = 1'b1;
      endcase
      desel_rot++;
    end
    if (cen)               wdata_i = 36'hF_0F0F_0F0F;
    else if (p2_kind == 2) wdata_i = p2_data;
    else                   wdata_i = 36'h3_C3C3_C3C3;
    if (!cen) begin
      if (kind == 1) nexp = ref_mem[eff];
      if (kind == 2) ref_mem[eff] = apply_lanes(ref_mem[eff], d, bwn);
    end
    @(posedge clk_i);
    @(negedge clk_i);
    if (cen) begin
      // R5 frozen edge
      chk(rdata_o === last_rd, "R5 rdata hold", rdata_o, last_rd);
      chk(drive_o === last_dr, "R5 drive hold", {35'b0, drive_o}, {35'b0, last_dr});
    end else begin
      if (p1_kind == 1) begin
        chk(drive_o === 1'b1, p1_tag, {35'b0, drive_o}, 36'd1);
        chk(rdata_o === p1_exp, p1_tag, rdata_o, p1_exp);
      end else begin
        chk(drive_o === 1'b0, p1_tag, {35'b0, drive_o}, 36'd0);
      end
      p2_kind = p1_kind;
      p2_data = p1_data;
      p1_kind = kind;
      p1_exp  = nexp;
      p1_data = d;
      p1_tag  = tag;
    end
    last_rd = rdata_o;
    last_dr = drive_o;
  endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] bwn, input logic [35:0] d, input string tag);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, a, bwn, 2, a, d, tag);
  endtask
  task automatic rd(input logic [9:0] a, input string tag);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, a, 4'hF, 1, a, '0, tag);
  endtask
  task automatic desel(input logic [9:0] a, input string tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, a, 4'h0, 0, a, '0, tag);
  endtask
  task automatic stall();
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 10'h3FF, 4'h0, 0, '0, '0, "R5");
  endtask
  task automatic adv(input logic we, input logic sel, input logic [3:0] bwn, input int kind,
                     input logic [9:0] eff, input logic [35:0] d, input string tag);
    cyc(1'b0, 1'b1, sel, we, 10'h2AA, bwn, kind, eff, d, tag);
  endtask
  task automatic flush(input string tag);
    desel(10'h000, tag);
    desel(10'h000, tag);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(drive_o === 1'b0, "R1 in reset", {35'b0, drive_o}, 36'd0);
    rst_ni = 1'b1;
    flush("R1");
    chk(drive_o === 1'b0, "R1 after reset", {35'b0, drive_o}, 36'd0);
  endtask

  task automatic t_basic();
    wr(10'h010, 4'h0, 36'h1_1111_2222, "R3");
    wr(10'h011, 4'h0, 36'hE_ABCD_EF01, "R3");
    rd(10'h010, "R2");
    rd(10'h011, "R2");
    flush("R2");
  endtask

  task automatic t_lanes();
    wr(10'h020, 4'h0, 36'h5_A5A5_A5A5, "R3");
    wr(10'h020, 4'b1010, 36'hA_1234_5678, "R3 lanes 0,2");
    rd(10'h020, "R3 masked");
    wr(10'h020, 4'b0111, 36'hF_FF00_0000, "R3 lane 3");
    flush("R3");
    rd(10'h020, "R3 lane 3");
    flush("R3");
  endtask

  task automatic t_mix();
    wr(10'h031, 4'h0, 36'h0_0000_0031, "R4");
    wr(10'h030, 4'h0, 36'h3_3030_3030, "R4");
    rd(10'h030, "R4 bypass");
    wr(10'h030, 4'b0111, 36'hC_9900_0000, "R4");
    rd(10'h030, "R4 partial bypass");
    rd(10'h031, "R4");
    wr(10'h031, 4'b1100, 36'h3_0000_BEEF, "R4");
    rd(10'h031, "R4 partial bypass");
    flush("R4");
  endtask

  task automatic t_stall();
    wr(10'h040, 4'h0, 36'h4_4040_4040, "R5");
    stall();
    stall();
    rd(10'h040, "R5 write across stall");
    stall();
    stall();
    rd(10'h040, "R5");
    stall();
    flush("R5");
  endtask

  task automatic t_oe();
    rd(10'h010, "R6");
    desel(10'h000, "R6");
    oe_ni = 1'b1;
    #1;
    chk(drive_o === 1'b0, "R6 oe high", {35'b0, drive_o}, 36'd0);
    oe_ni = 1'b0;
    #1;
    chk(drive_o === 1'b1, "R6 oe low", {35'b0, drive_o}, 36'd1);
    desel(10'h000, "R6");
  endtask

  task automatic t_desel();
    rd(10'h010, "R7");
    desel(10'h010, "R7 deselect");
    desel(10'h010, "R7 deselect");
    rd(10'h011, "R7 first after deselect");
    wr(10'h012, 4'h0, 36'h7_0000_0012, "R7 write slot");
    rd(10'h012, "R7");
    flush("R7");
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++) wr(10'h050 + 10'(i), 4'h0, 36'h5_0000_0050 + 36'(i * 'h111), "R8");
    flush("R8");
    burst_mode_i = 1'b0;
    rd(10'h052, "R8");
    adv(1'b1, 1'b1, 4'hF, 1, 10'h053, '0, "R8 beat1");
    adv(1'b1, 1'b1, 4'hF, 1, 10'h050, '0, "R8 beat2");
    adv(1'b1, 1'b1, 4'hF, 1, 10'h051, '0, "R8 beat3");
    adv(1'b1, 1'b1, 4'hF, 1, 10'h052, '0, "R8 wrap");
    flush("R8");
    burst_mode_i = 1'b1;
    rd(10'h051, "R9");
    adv(1'b1, 1'b1, 4'hF, 1, 10'h050, '0, "R9 beat1");
    adv(1'b1, 1'b1, 4'hF, 1, 10'h053, '0, "R9 beat2");
    adv(1'b1, 1'b1, 4'hF, 1, 10'h052, '0, "R9 beat3");
    flush("R9");
    burst_mode_i = 1'b0;
  endtask

  task automatic t_burst_type();
    wr(10'h060, 4'h0, 36'h6_0000_0060, "R10");
    adv(1'b1, 1'b0, 4'h0, 2, 10'h061, 36'h6_1111_0061, "R10 adv ignores we/sel");
    adv(1'b1, 1'b1, 4'h0, 2, 10'h062, 36'h6_2222_0062, "R10");
    flush("R10");
    rd(10'h060, "R10");
    rd(10'h061, "R10");
    rd(10'h062, "R10");
    adv(1'b0, 1'b0, 4'h0, 1, 10'h063, 36'hD_DDDD_DDDD, "R10 read burst stays read");
    flush("R10");
    wr(10'h063, 4'h0, 36'h6_3333_0063, "R10");
    rd(10'h060, "R10");
    adv(1'b0, 1'b1, 4'h0, 1, 10'h061, 36'hB_BBBB_BBBB, "R10 read burst stays read");
    flush("R10");
    rd(10'h061, "R10 no write");
    flush("R10");
  endtask

  task automatic t_adv_desel();
    desel(10'h050, "R11");
    adv(1'b0, 1'b1, 4'h0, 0, 10'h051, 36'h0_DEAD_0000, "R11 no access");
    adv(1'b0, 1'b1, 4'h0, 0, 10'h052, 36'h0_DEAD_0001, "R11 no access");
    adv(1'b1, 1'b1, 4'hF, 0, 10'h053, '0, "R11 no drive");
    flush("R11");
    rd(10'h050, "R11");
    rd(10'h051, "R11");
    rd(10'h052, "R11");
    rd(10'h053, "R11");
    flush("R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_lanes();
    t_mix();
    t_stall();
    t_oe();
    t_desel();
    t_burst();
    t_burst_type();
    t_adv_desel();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule